// File: doc/BRIEF.md
# Multi-Mode Shift and Rotate Unit

A datapath shifter for operands of one byte, two bytes (word) or four bytes (long). A single operation code selects among plain rotates, rotates that pass through the carry bit, static arithmetic and logical shifts, dynamic shifts whose direction follows the sign of a signed count, and decimal digit rotation. Digit rotation moves nibbles between a byte operand and a separate link nibble. Besides the result, the unit returns the updated link nibble and four condition flags: carry (C), zero (Z), sign (S) and parity/overflow (V).

The unit sits between an operand source and a register write-back stage. With the default `REG_OUT = 1`, every input is captured on a rising clock edge and the result appears at the outputs one cycle after it was presented. With `REG_OUT = 0` the outputs follow the inputs combinationally. The byte width `BW` sets all sizes: word = 2·BW, long = 4·BW, link = BW/2.

Top module: `shf_unit`

## Requirements
- R1: While `rst_n` is low, `result_o`, `link_o`, `c_o`, `z_o`, `s_o` and `v_o` are all zero.
- R2: Operation codes 0 (rotate left) and 1 (rotate right) circulate bits within the selected size. A count of exactly 2 moves two positions and any other count moves one. C takes the last bit carried around.
- R3: Operation codes 2 (rotate left through carry) and 3 (rotate right through carry) treat `carry_i` as an extra bit of the rotation, using the same count rule as R2. C ends as the last bit shifted out.
- R4: Operation codes 4 (arithmetic left) and 5 (logical left) fill vacated low bits with zero. The count is |count_i| clamped to the operand width, and C is the last bit shifted out.
- R5: Operation code 6 (arithmetic right) fills from the top with the operand's sign bit and code 7 (logical right) fills with zero. Both use the count rule of R4, and both force V to 0.
- R6: Operation codes 8 (dynamic arithmetic) and 9 (dynamic logical) shift left by the count when `count_i` is zero or positive, and right by its magnitude when it is negative (two's complement). Code 8 fills from the top with the sign bit when shifting right; code 9 fills with zero.
- R7: V is set when the sign bit of the selected size changed at any single step. This applies to codes 0 to 4 and to code 8 with a non-negative count; every other code gives V = 0.
- R8: `size_i` 0 selects byte, 1 selects word, and 2 or 3 select long. Result bits above the selected size are zero, Z is set when the result is zero, and S is the top bit of the selected size.
- R9: Code 10 (digit left) produces the byte {operand[3:0], link_i}, with link_o = operand[7:4]. Code 11 (digit right) produces {link_i, operand[7:4]}, with link_o = operand[3:0]. Both always work on a byte, and both give C = V = 0 with Z and S taken from the new byte. Every other code passes `link_i` to `link_o`.
- R10: With `REG_OUT = 1`, outputs update only on a rising clock edge and reflect the inputs present at that edge.
- R11: A shift whose count resolves to 0, or an unassigned code (12 to 15), returns the masked operand unchanged with C = V = 0. `carry_i` has no effect in either case.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_i | input | 4 | Operation code |
| size_i | input | 2 | Operand size select |
| operand_i | input | 4·BW | Operand value |
| count_i | input | $clog2(4·BW)+2 | Signed shift count |
| carry_i | input | 1 | Carry input for rotates through carry |
| link_i | input | BW/2 | Link nibble input |
| result_o | output | 4·BW | Shifted or rotated result |
| link_o | output | BW/2 | Updated link nibble |
| c_o | output | 1 | Carry flag |
| z_o | output | 1 | Zero flag |
| s_o | output | 1 | Sign flag |
| v_o | output | 1 | Parity/overflow flag |

## Verification
The result, link nibble and all four flags are due exactly one rising edge after their inputs are presented. The bench therefore drives stimulus on a falling edge and compares on the next falling edge, half a period after the capturing edge. One directed case changes the inputs and compares immediately, before the next rising edge, to confirm that the outputs still hold the earlier result. The reset check samples shortly after `rst_n` falls, with no clock edge in between.

// File: rtl/shf_pkg.sv
package shf_pkg;
   typedef enum logic [3:0] {
      OP_ROTL  = 4'd0,  OP_ROTR  = 4'd1,  OP_ROTCL = 4'd2,  OP_ROTCR = 4'd3,
      OP_SHAL  = 4'd4,  OP_SHLL  = 4'd5,  OP_SHAR  = 4'd6,  OP_SHLR  = 4'd7,
      OP_DYNA  = 4'd8,  OP_DYNL  = 4'd9,  OP_DIGL  = 4'd10, OP_DIGR  = 4'd11
   } shf_op_e;

   typedef enum logic [1:0] {
      FILL_ZERO, FILL_SIGN, FILL_CIRC, FILL_CARRY
   } shf_fill_e;
endpackage

// File: rtl/shf_decode.sv
module shf_decode import shf_pkg::*; #(
   parameter  int W  = 32,
   parameter  int BW = 8,
   localparam int CW = $clog2(W) + 2,
   localparam int AW = $clog2(W) + 1,
   localparam int MW = $clog2(W)
) (
   input  logic [3:0]    op_i,
   input  logic [1:0]    size_i,
   input  logic [CW-1:0] count_i,
   output logic [W-1:0]  mask_o,
   output logic [MW-1:0] msb_o,
   output logic [AW-1:0] amt_o,
   output logic          left_o,
   output shf_fill_e     fill_o,
   output logic          vtrack_o,
   output logic          digit_o,
   output logic          digit_left_o
);
   logic [AW-1:0] nbits;
   logic [CW-1:0] mag;
   logic [AW-1:0] clamped;
   logic          neg;

   always_comb begin
      digit_o      = (op_i == OP_DIGL) || (op_i == OP_DIGR);
      digit_left_o = (op_i == OP_DIGL);
      if (digit_o) nbits = AW'(BW);
      else begin
         case (size_i)
            2'd0:    nbits = AW'(BW);
            2'd1:    nbits = AW'(2 * BW);
            default: nbits = AW'(W);
         endcase
      end
      mask_o  = {W{1'b1}} >> (AW'(W) - nbits);
      msb_o   = MW'(nbits - 1'b1);
      neg     = count_i[CW-1];
      mag     = neg ? (~count_i + 1'b1) : count_i;
      clamped = (mag > CW'(nbits)) ? nbits : AW'(mag);

      left_o   = 1'b1;
      fill_o   = FILL_ZERO;
      vtrack_o = 1'b0;
      amt_o    = '0;
      case (shf_op_e'(op_i))
         OP_ROTL, OP_ROTR, OP_ROTCL, OP_ROTCR: begin
            amt_o    = (count_i == CW'(2)) ? AW'(2) : AW'(1);
            left_o   = (op_i == OP_ROTL) || (op_i == OP_ROTCL);
            fill_o   = ((op_i == OP_ROTCL) || (op_i == OP_ROTCR)) ? FILL_CARRY : FILL_CIRC;
            vtrack_o = 1'b1;
         end
         OP_SHAL: begin amt_o = clamped; vtrack_o = 1'b1; end
         OP_SHLL: amt_o = clamped;
         OP_SHAR: begin amt_o = clamped; left_o = 1'b0; fill_o = FILL_SIGN; end
         OP_SHLR: begin amt_o = clamped; left_o = 1'b0; end
         OP_DYNA: begin
            amt_o    = clamped;
            left_o   = !neg;
            fill_o   = neg ? FILL_SIGN : FILL_ZERO;
            vtrack_o = !neg;
         end
         OP_DYNL: begin amt_o = clamped; left_o = !neg; end
         default: ;
      endcase
   end
endmodule

// File: rtl/shf_stepper.sv
module shf_stepper import shf_pkg::*; #(
   parameter  int W  = 32,
   localparam int AW = $clog2(W) + 1,
   localparam int MW = $clog2(W)
) (
   input  logic [W-1:0]  data_i,
   input  logic [W-1:0]  mask_i,
   input  logic [MW-1:0] msb_i,
   input  logic [AW-1:0] amt_i,
   input  logic          left_i,
   input  shf_fill_e     fill_i,
   input  logic          vtrack_i,
   input  logic          carry_i,
   output logic [W-1:0]  res_o,
   output logic          c_o,
   output logic          v_o
);
   logic [W-1:0] acc;
   logic         cy, last, old_top, fb, ov;

   // One single-bit step per loop pass; the loop unrolls to W stages.
   always_comb begin
      acc     = data_i & mask_i;
      cy      = carry_i;
      last    = 1'b0;
      old_top = 1'b0;
      fb      = 1'b0;
      ov      = 1'b0;
      for (int k = 0; k < W; k++) begin
         if (k < int'(amt_i)) begin
            old_top = acc[msb_i];
            last    = left_i ? old_top : acc[0];
            case (fill_i)
               FILL_CIRC:  fb = last;
               FILL_CARRY: fb = cy;
               FILL_SIGN:  fb = old_top;
               default:    fb = 1'b0;
            endcase
            if (left_i) acc = ((acc << 1) & mask_i) | W'(fb);
            else begin
               acc        = acc >> 1;
               acc[msb_i] = fb;
            end
            cy = last;
            if (acc[msb_i] != old_top) ov = 1'b1;
         end
      end
      res_o = acc;
      c_o   = last;
      v_o   = vtrack_i & ov;
   end
endmodule

// File: rtl/shf_digit.sv
module shf_digit #(
   parameter  int BW = 8,
   localparam int LW = BW / 2
) (
   input  logic [BW-1:0] byte_i,
   input  logic [LW-1:0] link_i,
   input  logic          left_i,
   output logic [BW-1:0] byte_o,
   output logic [LW-1:0] link_o
);
   always_comb begin
      if (left_i) begin
         byte_o = {byte_i[LW-1:0], link_i};
         link_o = byte_i[BW-1:LW];
      end else begin
         byte_o = {link_i, byte_i[BW-1:LW]};
         link_o = byte_i[LW-1:0];
      end
   end
endmodule

// File: rtl/shf_unit.sv
module shf_unit import shf_pkg::*; #(
   parameter  int BW      = 8,
   parameter  bit REG_OUT = 1'b1,
   localparam int W       = 4 * BW,
   localparam int LW      = BW / 2,
   localparam int CW      = $clog2(W) + 2,
   localparam int AW      = $clog2(W) + 1,
   localparam int MW      = $clog2(W)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [3:0]    op_i,
   input  logic [1:0]    size_i,
   input  logic [W-1:0]  operand_i,
   input  logic [CW-1:0] count_i,
   input  logic          carry_i,
   input  logic [LW-1:0] link_i,
   output logic [W-1:0]  result_o,
   output logic [LW-1:0] link_o,
   output logic          c_o,
   output logic          z_o,
   output logic          s_o,
   output logic          v_o
);
   if ((BW % 2) != 0 || BW < 4) begin : g_bad_bw
      $error("shf_unit: BW must be even and at least 4");
   end

   logic [W-1:0]  mask_w, step_res, nx_res;
   logic [MW-1:0] msb_w;
   logic [AW-1:0] amt_w;
   logic          left_w, vtrack_w, digit_w, digit_left_w;
   shf_fill_e     fill_w;
   logic          step_c, step_v;
   logic [BW-1:0] dig_byte;
   logic [LW-1:0] dig_link, nx_link;
   logic          nx_c, nx_z, nx_s, nx_v;

   shf_decode #(.W(W), .BW(BW)) u_decode (
      .op_i(op_i), .size_i(size_i), .count_i(count_i),
      .mask_o(mask_w), .msb_o(msb_w), .amt_o(amt_w), .left_o(left_w),
      .fill_o(fill_w), .vtrack_o(vtrack_w), .digit_o(digit_w),
      .digit_left_o(digit_left_w)
   );

   shf_stepper #(.W(W)) u_stepper (
      .data_i(operand_i), .mask_i(mask_w), .msb_i(msb_w), .amt_i(amt_w),
      .left_i(left_w), .fill_i(fill_w), .vtrack_i(vtrack_w), .carry_i(carry_i),
      .res_o(step_res), .c_o(step_c), .v_o(step_v)
   );

   shf_digit #(.BW(BW)) u_digit (
      .byte_i(operand_i[BW-1:0]), .link_i(link_i), .left_i(digit_left_w),
      .byte_o(dig_byte), .link_o(dig_link)
   );

   always_comb begin
      if (digit_w) begin
         nx_res  = W'(dig_byte);
         nx_link = dig_link;
         nx_c    = 1'b0;
         nx_v    = 1'b0;
      end else begin
         nx_res  = step_res;
         nx_link = link_i;
         nx_c    = step_c;
         nx_v    = step_v;
      end
      nx_z = (nx_res == '0);
      nx_s = nx_res[msb_w];
   end

   if (REG_OUT) begin : g_reg
      logic seen_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            result_o <= '0;
            link_o   <= '0;
            c_o      <= 1'b0;
            z_o      <= 1'b0;
            s_o      <= 1'b0;
            v_o      <= 1'b0;
            seen_q   <= 1'b0;
         end else begin
            result_o <= nx_res;
            link_o   <= nx_link;
            c_o      <= nx_c;
            z_o      <= nx_z;
            s_o      <= nx_s;
            v_o      <= nx_v;
            seen_q   <= 1'b1;
         end
      end

      assert_rot_ones_R2: assert property (@(posedge clk) disable iff (!rst_n)
         seen_q && ($past(op_i) == OP_ROTL || $past(op_i) == OP_ROTR)
         |-> $countones(result_o) == $countones($past(operand_i & mask_w)));

      assert_right_no_ov_R5: assert property (@(posedge clk) disable iff (!rst_n)
         seen_q && ($past(op_i) == OP_SHAR || $past(op_i) == OP_SHLR) |-> !v_o);

      assert_right_sign_keep_R5: assert property (@(posedge clk) disable iff (!rst_n)
         seen_q && $past(op_i) == OP_SHAR |-> s_o == $past(operand_i[msb_w]));

      assert_upper_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
         seen_q |-> (result_o & ~$past(mask_w)) == '0);

      assert_link_pass_R9: assert property (@(posedge clk) disable iff (!rst_n)
         seen_q && !$past(digit_w) |-> link_o == $past(link_i));
   end else begin : g_comb
      assign result_o = nx_res;
      assign link_o   = nx_link;
      assign c_o      = nx_c;
      assign z_o      = nx_z;
      assign s_o      = nx_s;
      assign v_o      = nx_v;
   end
endmodule

// File: tb/test_shf_unit.sv
`timescale 1ns/1ps
module test_shf_unit;
   localparam int BW = 8;
   localparam int W  = 4 * BW;
   localparam int LW = BW / 2;
   localparam int CW = $clog2(W) + 2;
   localparam int NV = 24;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [3:0]    op_i = '0;
   logic [1:0]    size_i = '0;
   logic [W-1:0]  operand_i = '0;
   logic [CW-1:0] count_i = '0;
   logic          carry_i = 1'b0;
   logic [LW-1:0] link_i = '0;
   logic [W-1:0]  result_o;
   logic [LW-1:0] link_o;
   logic          c_o, z_o, s_o, v_o;

   int tests = 0;
   int fails = 0;
   bit done  = 1'b0;

   always #4 clk = ~clk;

   shf_unit #(.BW(BW)) i_shf_unit (
      .clk(clk), .rst_n(rst_n), .op_i(op_i), .size_i(size_i),
      .operand_i(operand_i), .count_i(count_i), .carry_i(carry_i), .link_i(link_i),
      .result_o(result_o), .link_o(link_o), .c_o(c_o), .z_o(z_o), .s_o(s_o), .v_o(v_o)
   );

   // {req, op, size, operand, count, carry, link, exp result, exp link, exp {C,Z,S,V}}
   localparam logic [93:0] VEC [NV] = '{
      {4'd2,  4'd0,  2'd0, 32'h00000081, 7'd1,   1'b0, 4'hA, 32'h00000003, 4'hA, 4'b1001}, // R2 rotl byte
      {4'd2,  4'd1,  2'd1, 32'h00000001, 7'd2,   1'b0, 4'hA, 32'h00004000, 4'hA, 4'b0001}, // R2 rotr word x2
      {4'd3,  4'd2,  2'd0, 32'h00000080, 7'd1,   1'b0, 4'hA, 32'h00000000, 4'hA, 4'b1101}, // R3 rotcl byte
      {4'd3,  4'd3,  2'd2, 32'h00000001, 7'd2,   1'b1, 4'hA, 32'hC0000000, 4'hA, 4'b0011}, // R3 rotcr long x2
      {4'd7,  4'd4,  2'd1, 32'h00004000, 7'd1,   1'b0, 4'hA, 32'h00008000, 4'hA, 4'b0011}, // R7 shal sign flip
      {4'd4,  4'd5,  2'd0, 32'h0000000F, 7'd4,   1'b0, 4'hA, 32'h000000F0, 4'hA, 4'b0010}, // R4 shll byte
      {4'd4,  4'd5,  2'd0, 32'h000000FF, 7'd40,  1'b0, 4'hA, 32'h00000000, 4'hA, 4'b1100}, // R4 count clamp
      {4'd5,  4'd6,  2'd0, 32'h00000090, 7'd3,   1'b0, 4'hA, 32'h000000F2, 4'hA, 4'b0010}, // R5 shar byte
      {4'd5,  4'd6,  2'd1, 32'h00008001, 7'd1,   1'b0, 4'hA, 32'h0000C000, 4'hA, 4'b1010}, // R5 shar word
      {4'd5,  4'd7,  2'd2, 32'h80000003, 7'd2,   1'b0, 4'hA, 32'h20000000, 4'hA, 4'b1000}, // R5 shlr long
      {4'd6,  4'd8,  2'd2, 32'h00000003, 7'd1,   1'b0, 4'hA, 32'h00000006, 4'hA, 4'b0000}, // R6 dyna left
      {4'd6,  4'd8,  2'd0, 32'h00000084, 7'h7E,  1'b0, 4'hA, 32'h000000E1, 4'hA, 4'b0010}, // R6 dyna -2
      {4'd6,  4'd9,  2'd1, 32'h00000003, 7'h7F,  1'b0, 4'hA, 32'h00000001, 4'hA, 4'b1000}, // R6 dynl -1
      {4'd6,  4'd9,  2'd1, 32'h00000003, 7'd15,  1'b0, 4'hA, 32'h00008000, 4'hA, 4'b1010}, // R6 dynl +15
      {4'd9,  4'd10, 2'd0, 32'h0000005C, 7'd0,   1'b0, 4'h3, 32'h000000C3, 4'h5, 4'b0010}, // R9 digit left
      {4'd9,  4'd11, 2'd0, 32'h0000005C, 7'd0,   1'b0, 4'h3, 32'h00000035, 4'hC, 4'b0000}, // R9 digit right
      {4'd9,  4'd10, 2'd2, 32'h00000000, 7'd0,   1'b0, 4'h0, 32'h00000000, 4'h0, 4'b0100}, // R9 digit zero
      {4'd7,  4'd4,  2'd0, 32'h00000040, 7'd2,   1'b0, 4'hA, 32'h00000000, 4'hA, 4'b1101}, // R7 flip then back
      {4'd11, 4'd5,  2'd1, 32'h00001234, 7'd0,   1'b1, 4'hA, 32'h00001234, 4'hA, 4'b0000}, // R11 count zero
      {4'd11, 4'd14, 2'd2, 32'h80000000, 7'd5,   1'b1, 4'hA, 32'h80000000, 4'hA, 4'b0010}, // R11 unassigned op
      {4'd8,  4'd0,  2'd0, 32'hFFFFFF01, 7'd1,   1'b0, 4'hA, 32'h00000002, 4'hA, 4'b0000}, // R8 upper bits cleared
      {4'd5,  4'd6,  2'd2, 32'h80000000, 7'd32,  1'b0, 4'hA, 32'hFFFFFFFF, 4'hA, 4'b1010}, // R5 full width sign
      {4'd4,  4'd7,  2'd3, 32'h80000000, 7'd32,  1'b0, 4'hA, 32'h00000000, 4'hA, 4'b1100}, // R4 full width, size 3
      {4'd7,  4'd8,  2'd1, 32'h00004000, 7'd2,   1'b0, 4'hA, 32'h00000000, 4'hA, 4'b1101}  // R7 dyna left flips
   };

   task automatic chk(input string tag, input logic [W-1:0] got, input logic [W-1:0] exp);
      tests++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s: got %h expected %h", tag, got, exp);
      end
   endtask

   task automatic drive(input logic [3:0] op, input logic [1:0] sz, input logic [W-1:0] opd,
                        input logic [CW-1:0] cnt, input logic cin, input logic [LW-1:0] lnk);
      op_i = op; size_i = sz; operand_i = opd; count_i = cnt; carry_i = cin; link_i = lnk;
   endtask

   task automatic chk_zero_outputs(input string tag);
      chk({tag, " result"}, result_o, '0);
      chk({tag, " link"}, W'(link_o), '0);
      chk({tag, " flags"}, W'({c_o, z_o, s_o, v_o}), '0);
   endtask

   initial begin
      // R1: outputs cleared while reset is held
      #13;
      chk_zero_outputs("R1 initial reset");
      @(negedge clk);
      rst_n = 1'b1;

      for (int i = 0; i < NV; i++) begin
         @(negedge clk);
         drive(VEC[i][89:86], VEC[i][85:84], VEC[i][83:52], VEC[i][51:45], VEC[i][44], VEC[i][43:40]);
         @(negedge clk);
         chk($sformatf("R%0d vec%0d result", VEC[i][93:90], i), result_o, VEC[i][39:8]);
         chk($sformatf("R%0d vec%0d link", VEC[i][93:90], i), W'(link_o), W'(VEC[i][7:4]));
         chk($sformatf("R%0d vec%0d flags CZSV", VEC[i][93:90], i),
             W'({c_o, z_o, s_o, v_o}), W'(VEC[i][3:0]));
      end

      // R10: outputs hold between edges and follow the captured inputs
      @(negedge clk);
      drive(4'd0, 2'd0, 32'h81, 7'd1, 1'b0, 4'hA);
      @(negedge clk);
      chk("R10 first result", result_o, 32'h3);
      drive(4'd5, 2'd0, 32'h0F, 7'd4, 1'b0, 4'hA);
      #1;
      chk("R10 held before edge", result_o, 32'h3);
      @(negedge clk);
      chk("R10 next result", result_o, 32'hF0);

      // R3: carry_i alters a rotate through carry
      drive(4'd2, 2'd0, 32'h00, 7'd1, 1'b1, 4'hA);
      @(negedge clk);
      chk("R3 carry enters low bit", result_o, 32'h1);

      // R1: mid-run reset clears registered outputs without a clock edge
      drive(4'd6, 2'd2, 32'h80000000, 7'd1, 1'b1, 4'h7);
      @(negedge clk);
      rst_n = 1'b0;
      #1;
      chk_zero_outputs("R1 mid-run reset");
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R5 after reset release", result_o, 32'hC0000000);

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      #(8 * 20000);
      if (!done) begin
         fails++;
         tests++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end
endmodule